// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns a stored mode word and a burst start request into a stream of column addresses, one per clock, for the length of the burst. The mode word carries a burst length code, an order bit and a write-single bit. A burst of two, four or eight beats stays inside the naturally aligned block that holds the start column. The in-block bits either count upward and wrap, or are the start bits XORed with the beat index. A full-page burst walks the whole row upward, wraps from the top column to column zero, and runs until a terminate input is asserted.

Each beat is qualified by a valid strobe. The final beat of a fixed-length burst carries a last flag. Reserved length codes, and a full page combined with interleaved order, raise a one-cycle error pulse and start no burst. When write-single mode is set, write bursts issue one column whatever length is programmed. Read bursts are not affected by that bit. A new start request always takes over from a running burst.

Top module: `burst_col_seq`

## Requirements
- R1: Length code `cfg_len` selects the beat count: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page. On a fixed-length burst, `col_last` is high on the final beat only.
- R2: With `cfg_ilv`=0 and a fixed length of 2, 4 or 8, the low 1, 2 or 3 column bits count up from the start value modulo the length, and all higher bits equal the start column on every beat.
- R3: With `cfg_ilv`=1 and a fixed length of 2, 4 or 8, beat i has its low 1, 2 or 3 bits equal to the start's low bits XOR i, and all higher bits equal the start column.
- R4: A full-page burst issues start, start+1, … modulo PAGE_COLS. It keeps issuing beats until `stop` is sampled high, and `col_last` stays low throughout.
- R5: A full-page code with `cfg_ilv`=1 causes `cfg_err` to be high for one cycle after the start, and no beat is issued. This holds unless the start is a write-single access (R8).
- R6: Length codes 100, 101 and 110 cause `cfg_err` to be high for one cycle after the start, and no beat is issued.
- R7: With length one, exactly the start column is issued whatever `cfg_ilv` holds.
- R8: When `cfg_wsingle`=1 and `start_wr`=1, one beat at the start column is issued, whatever length and order are programmed (reserved codes still error). With `start_wr`=0 the programmed length is used.
- R9: A start with a valid setting issues beat 0 in the next cycle. If a burst is already running, that burst is abandoned.
- R10: `col_vld` is high exactly on burst beats. It is low the cycle after the last beat, and low the cycle after `stop` is sampled during any burst, unless a new start is given.
- R11: While reset is held, `col_vld`, `col_last` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 3 | Burst length code |
| cfg_ilv | input | 1 | Order: 0 sequential, 1 interleaved |
| cfg_wsingle | input | 1 | Write bursts issue a single column |
| start | input | 1 | Burst start request |
| start_wr | input | 1 | Start request is a write |
| start_col | input | COL_W | Starting column |
| stop | input | 1 | Terminate the running burst |
| col_out | output | COL_W | Column of the current beat |
| col_vld | output | 1 | Beat valid strobe |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | Rejected start (reserved or unsupported setting) |

## Verification
Assertions check on every cycle that the column bits above the aligned block stay fixed during fixed bursts. They also check that full-page beats increment by one with wrap, that an error never coincides with a beat, that the last beat is followed by idle, and that a valid start yields its start column next. The actual beat orders need the bench's sweep over every length code, both orders, all eight in-block start offsets and the read and write-single cases. So do beat counts, the error decode and the abort and terminate paths.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [2:0] {
    BK_ONE   = 3'd0,
    BK_TWO   = 3'd1,
    BK_FOUR  = 3'd2,
    BK_EIGHT = 3'd3,
    BK_PAGE  = 3'd4
  } burst_kind_e;

  // number of in-block column bits for a fixed-length kind
  function automatic int unsigned kind_bits(burst_kind_e k);
    case (k)
      BK_TWO:   return 1;
      BK_FOUR:  return 2;
      BK_EIGHT: return 3;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_seq_pkg::*;
(
  input  logic [2:0]  len_code,
  input  logic        ilv,
  input  logic        wsingle,
  input  logic        is_wr,
  output burst_kind_e kind,
  output logic        ilv_eff,
  output logic        cfg_ok
);

  logic force_one;
  logic reserved;

  always_comb begin
    force_one = wsingle & is_wr;
    reserved  = 1'b0;
    kind      = BK_ONE;
    case (len_code)
      3'b000:  kind = BK_ONE;
      3'b001:  kind = BK_TWO;
      3'b010:  kind = BK_FOUR;
      3'b011:  kind = BK_EIGHT;
      3'b111:  kind = BK_PAGE;
      default: reserved = 1'b1;
    endcase
    if (force_one) kind = BK_ONE;
    ilv_eff = ilv & (kind != BK_ONE);
    cfg_ok  = !reserved && !((kind == BK_PAGE) && ilv);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  burst_kind_e      kind,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  localparam int unsigned LOW_MAX = 3;

  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] mix;

  // bit b belongs to the moving field when below the block width, or always for a page
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    if (b < LOW_MAX) begin : g_low
      assign mask[b] = (kind == BK_PAGE) || (kind_bits(kind) > b);
    end else begin : g_high
      assign mask[b] = (kind == BK_PAGE);
    end
  end

  always_comb begin
    sum = base + beat;
    mix = base ^ beat;
    if (ilv) col = (base & ~mask) | (mix & mask);
    else     col = (base & ~mask) | (sum & mask);
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  burst_kind_e      kind_in,
  input  logic             ilv_in,
  input  logic             cfg_ok,
  output logic             busy,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output burst_kind_e      kind,
  output logic             ilv,
  output logic             last,
  output logic             err
);

  logic             busy_q, busy_d;
  logic             err_q, err_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  burst_kind_e      kind_q, kind_d;
  logic             ilv_q, ilv_d;
  logic             cfg_en, beat_en;
  logic [COL_W-1:0] last_idx;

  always_comb begin
    case (kind_q)
      BK_TWO:   last_idx = COL_W'(1);
      BK_FOUR:  last_idx = COL_W'(3);
      BK_EIGHT: last_idx = COL_W'(7);
      default:  last_idx = '0;
    endcase
    last = busy_q && (kind_q != BK_PAGE) && (beat_q == last_idx);
  end

  always_comb begin
    busy_d  = busy_q;
    err_d   = 1'b0;
    base_d  = base_q;
    beat_d  = beat_q;
    kind_d  = kind_q;
    ilv_d   = ilv_q;
    cfg_en  = 1'b0;
    beat_en = 1'b0;
    if (start) begin
      beat_en = 1'b1;
      beat_d  = '0;
      if (cfg_ok) begin
        busy_d = 1'b1;
        cfg_en = 1'b1;
        base_d = start_col;
        kind_d = kind_in;
        ilv_d  = ilv_in;
      end else begin
        busy_d = 1'b0;
        err_d  = 1'b1;
      end
    end else if (busy_q) begin
      if (stop || last) begin
        busy_d = 1'b0;
      end else begin
        beat_en = 1'b1;
        beat_d  = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      kind_q <= BK_ONE;
      ilv_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      if (cfg_en) begin
        base_q <= base_d;
        kind_q <= kind_d;
        ilv_q  <= ilv_d;
      end
      if (beat_en) beat_q <= beat_d;
    end
  end

  assign busy = busy_q;
  assign base = base_q;
  assign beat = beat_q;
  assign kind = kind_q;
  assign ilv  = ilv_q;
  assign err  = err_q;

  // R10
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !busy);

  // R5 R6
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned PAGE_COLS = 1024,
  localparam int unsigned COL_W    = $clog2(PAGE_COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_len,
  input  logic             cfg_ilv,
  input  logic             cfg_wsingle,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_vld,
  output logic             col_last,
  output logic             cfg_err
);

  logic             rst_meta, rst_sync;
  burst_kind_e      dec_kind, run_kind;
  logic             dec_ilv, dec_ok, run_ilv;
  logic [COL_W-1:0] run_base, run_beat;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  burst_cfg_decode i_dec (
    .len_code (cfg_len),
    .ilv      (cfg_ilv),
    .wsingle  (cfg_wsingle),
    .is_wr    (start_wr),
    .kind     (dec_kind),
    .ilv_eff  (dec_ilv),
    .cfg_ok   (dec_ok)
  );

  burst_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .kind_in   (dec_kind),
    .ilv_in    (dec_ilv),
    .cfg_ok    (dec_ok),
    .busy      (col_vld),
    .base      (run_base),
    .beat      (run_beat),
    .kind      (run_kind),
    .ilv       (run_ilv),
    .last      (col_last),
    .err       (cfg_err)
  );

  burst_addr_gen #(.COL_W(COL_W)) i_gen (
    .base (run_base),
    .beat (run_beat),
    .kind (run_kind),
    .ilv  (run_ilv),
    .col  (col_out)
  );

  // R11
  always_comb begin
    if (!rst_n) begin
      reset_idle_chk: assert (!col_vld && !col_last && !cfg_err);
    end
  end

  // R2
  high_bits_fixed_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (col_vld && $past(col_vld) && !$past(start) && (run_kind != BK_PAGE))
      |-> (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

  // R4
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (col_vld && $past(col_vld) && !$past(start) && (run_kind == BK_PAGE))
      |-> (col_out == COL_W'($past(col_out) + 1'b1)));

  // R9
  start_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (start && dec_ok) |=> (col_vld && (col_out == $past(start_col))));

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

  localparam int PAGE = 1024;
  localparam int CW   = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cfg_len = '0;
  logic          cfg_ilv = 1'b0;
  logic          cfg_wsingle = 1'b0;
  logic          start = 1'b0;
  logic          start_wr = 1'b0;
  logic [CW-1:0] start_col = '0;
  logic          stop = 1'b0;
  logic [CW-1:0] col_out;
  logic          col_vld, col_last, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq #(.PAGE_COLS(PAGE)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv),
    .cfg_wsingle(cfg_wsingle), .start(start), .start_wr(start_wr),
    .start_col(start_col), .stop(stop), .col_out(col_out),
    .col_vld(col_vld), .col_last(col_last), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // in-block width: 0,1,2,3 or -1 for a full page
  function automatic int blk_bits(int code, bit wr, bit ws);
    if (wr && ws) return 0;
    case (code)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_col(int nb, bit ilv, int base, int i);
    int m;
    if (nb < 0) return (base + i) % PAGE;
    m = (1 << nb) - 1;
    if (ilv) return (base & ~m) | ((base ^ i) & m);
    return (base & ~m) | ((base + i) & m);
  endfunction

  task automatic run_burst(input int code, input bit ilv, input bit wr, input bit ws,
                           input int base, input int page_beats);
    int nb, len;
    bit err;
    string tag;
    nb  = blk_bits(code, wr, ws);
    err = (code >= 4 && code <= 6) || (code == 7 && ilv && !(wr && ws));
    if (wr && ws)      tag = "R8";
    else if (nb < 0)   tag = "R4";
    else if (nb == 0)  tag = "R7";
    else if (ilv)      tag = "R3";
    else               tag = "R2";
    len = (nb < 0) ? page_beats : (1 << nb);
    @(negedge clk);
    cfg_len = 3'(code); cfg_ilv = ilv; start_wr = wr; cfg_wsingle = ws;
    start_col = CW'(base); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (err) begin
      chk(cfg_err == 1'b1, (code == 7) ? "R5 err" : "R6 err", cfg_err, 1);
      chk(col_vld == 1'b0, (code == 7) ? "R5 no beat" : "R6 no beat", col_vld, 0);
      @(negedge clk);
      chk(col_vld == 1'b0 && cfg_err == 1'b0, "R10 idle after error", col_vld, 0);
      return;
    end
    chk(cfg_err == 1'b0, "R1 no error", cfg_err, 0);
    for (int i = 0; i < len; i++) begin
      chk(col_vld == 1'b1, "R10 valid", col_vld, 1);
      chk(int'(col_out) == exp_col(nb, ilv, base, i), tag, col_out, exp_col(nb, ilv, base, i));
      chk(col_last == ((nb >= 0) && (i == len - 1)), "R1 last", col_last,
          int'((nb >= 0) && (i == len - 1)));
      if (nb < 0 && i == len - 1) stop = 1'b1;
      if (i < len - 1) @(negedge clk);
    end
    @(negedge clk);
    stop = 1'b0;
    chk(col_vld == 1'b0, "R10 idle after burst", col_vld, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!col_vld && !col_last && !cfg_err, "R11 reset", {col_vld, col_last, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!col_vld && !cfg_err, "R11 after release", col_vld, 0);

    for (int code = 0; code < 8; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int m = 0; m < 4; m++)
          for (int s = 0; s < 8; s++)
            run_burst(code, ilv[0], m[0], m[1],
                      (code == 7) ? (PAGE - 8 + s) : (8 * (13 + 5 * s) + s), 12);

    // long full-page read across the whole row and its wrap
    run_burst(7, 1'b0, 1'b0, 1'b0, 700, PAGE + 5);

    // R9: abort a length-8 burst with a new length-4 start
    @(negedge clk);
    cfg_len = 3'd3; cfg_ilv = 1'b0; start_wr = 1'b0; cfg_wsingle = 1'b0;
    start_col = CW'(16); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(col_vld && int'(col_out) == 18, "R9 before abort", col_out, 18);
    cfg_len = 3'd2; start_col = CW'(41); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(col_vld && int'(col_out) == exp_col(2, 1'b0, 41, i), "R9 restart", col_out,
          exp_col(2, 1'b0, 41, i));
      chk(col_last == (i == 3), "R9 last", col_last, int'(i == 3));
      @(negedge clk);
    end
    chk(!col_vld, "R9 idle", col_vld, 0);

    // R10: stop ends a fixed burst early
    cfg_len = 3'd3; start_col = CW'(100); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(col_vld && int'(col_out) == 101, "R10 beat before stop", col_out, 101);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(!col_vld, "R10 stopped", col_vld, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule